// File: doc/BRIEF.md
# UART receive FIFO controller

This block is the receive-side queue of a 16550-style serial port. A deserializer hands it one byte per strobe, or a break indication, and the block stores them in a small first-in first-out byte queue. The host side reads the head byte through a receive-buffer read strobe and programs the block through a write of the FIFO control byte, which carries the FIFO enable, a receive-queue flush and a two-bit trigger-level selector.

From the queue state the block derives the line-status flags (data ready, break seen, overrun) and the receive interrupt requests. The received-data request rises when the fill count reaches the programmed trigger level. A character-timeout request rises when data has sat in the queue for four character times with no byte arriving and no read. A two-bit interrupt identity combines these with an externally supplied transmit-empty request, in fixed priority. With the FIFO disabled, the queue holds a single byte, the trigger level is ignored and no timeout is raised.

Top module: `uart_rx_fifo_ctrl`

## Requirements
- R1: With FIFO mode on, the queue holds up to DEPTH (default 16) bytes and returns them in arrival order; `rx_count` reports the fill level, which is 0 after reset.
- R2: A byte or break that arrives while the queue is full, with no read in the same cycle, is dropped: count and contents stay as they were and `overrun_err` goes to 1. A read in the same cycle makes room, so the byte is kept and no overrun is flagged. `overrun_err` returns to 0 on `status_rd`, unless a new drop happens in that cycle.
- R3: Control-byte bits 7:6 select the trigger level: 2'b00 gives 1 byte, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14.
- R4: `rx_data_irq` is 1 when `rx_irq_en` is 1, the queue is non-empty, and, in FIFO mode, the count is at least the trigger level. In non-FIFO mode, a non-empty queue alone is enough.
- R5: `irq_code` gives 2'b11 for a pending character timeout (when `rx_irq_en` is 1), else 2'b10 for `rx_data_irq`, else 2'b01 for `tx_empty_req`, else 2'b00.
- R6: A `rx_break` strobe pushes byte 0x00 (it wins over `rx_byte` in the same cycle) and sets `break_ind`, which leaves `data_ready` at 1 one cycle later.
- R7: `rd_data` shows the head byte. A `rd_strobe` on a non-empty queue removes it. A read that leaves the queue empty clears `break_ind`, unless a break arrives in the same cycle.
- R8: A control write with bit 1 set empties the queue, discards any byte arriving in that cycle, clears `break_ind`, stops the timeout counter and clears a pending timeout.
- R9: In FIFO mode, an accepted byte, or a read that leaves data behind, loads the timeout counter with 4*CHAR_CYCLES. If no further byte or read follows, the timeout becomes pending exactly that many clock edges later. Any `rd_strobe` clears a pending timeout.
- R10: Control bit 0 selects FIFO mode. In non-FIFO mode the capacity is one byte and no timeout is ever pending. A control write that changes bit 0 also empties the queue, as in R8.
- R11: A read of an empty queue returns 0x00 on `rd_data` and leaves the count at 0.
- R12: `data_ready` is 1 exactly when the queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_wr | input | 1 | Strobe: write of the FIFO control byte |
| fcr_data | input | 8 | Control byte: bit 0 FIFO enable, bit 1 receive flush, bits 7:6 trigger level |
| rx_valid | input | 1 | Strobe: a received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte from the deserializer |
| rx_break | input | 1 | Strobe: a break condition was detected |
| rd_strobe | input | 1 | Strobe: host read of the receive buffer |
| status_rd | input | 1 | Strobe: host read of line status, clears the overrun flag |
| rx_irq_en | input | 1 | Receive interrupt enable |
| tx_empty_req | input | 1 | Transmit-holding-empty request from the transmit side |
| rd_data | output | 8 | Head byte of the queue, 0x00 when empty |
| rx_count | output | $clog2(DEPTH+1) | Number of bytes stored |
| data_ready | output | 1 | Queue is non-empty |
| break_ind | output | 1 | A break was received and not yet drained |
| overrun_err | output | 1 | A byte was dropped on a full queue |
| rx_data_irq | output | 1 | Received-data interrupt request |
| irq_code | output | 2 | Highest-priority pending interrupt identity |

## Verification
The hardest state to reach from the ports is a timeout expiry: the queue has to sit untouched for exactly 4*CHAR_CYCLES edges, which random traffic with frequent pushes and reads almost never allows. The stimulus therefore inserts long idle runs into the random traffic, and directed sequences check the edge just before expiry and the expiry edge, both after a push and after a read that leaves data. The other hard case is a full queue that gets a push and a read in the same cycle. This is driven on purpose after the queue has been filled to capacity, to separate a kept byte from a dropped one.

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl #(
  parameter int DEPTH       = 16,
  parameter int CHAR_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fcr_wr,
  input  logic [7:0]                   fcr_data,
  input  logic                         rx_valid,
  input  logic [7:0]                   rx_byte,
  input  logic                         rx_break,
  input  logic                         rd_strobe,
  input  logic                         status_rd,
  input  logic                         rx_irq_en,
  input  logic                         tx_empty_req,
  output logic [7:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   rx_count,
  output logic                         data_ready,
  output logic                         break_ind,
  output logic                         overrun_err,
  output logic                         rx_data_irq,
  output logic [1:0]                   irq_code
);

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int TMO_LOAD = 4 * CHAR_CYCLES;
  localparam int TMO_W    = $clog2(TMO_LOAD + 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count, cap, level, next_count;
  logic             fifo_on;
  logic [1:0]       lvl_sel;
  logic [TMO_W-1:0] tmo;
  logic             pend;

  logic flush, pop, push, accept, drop;
  logic [7:0] push_byte;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    unique case (lvl_sel)
      2'b00:   level = CNT_W'(1);
      2'b01:   level = CNT_W'(4);
      2'b10:   level = CNT_W'(8);
      default: level = CNT_W'(14);
    endcase
  end

  assign flush      = fcr_wr & (fcr_data[1] | (fcr_data[0] != fifo_on));
  assign cap        = fifo_on ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pop        = rd_strobe & (count != '0);
  assign push       = rx_valid | rx_break;
  assign push_byte  = rx_break ? 8'h00 : rx_byte;
  assign accept     = push & ((count < cap) | pop);
  assign drop       = push & ~accept;
  assign next_count = count + CNT_W'(accept) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (accept && !flush) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      fifo_on     <= 1'b0;
      lvl_sel     <= 2'b00;
      break_ind   <= 1'b0;
      overrun_err <= 1'b0;
      tmo         <= '0;
      pend        <= 1'b0;
    end else begin
      if (fcr_wr) begin
        fifo_on <= fcr_data[0];
        lvl_sel <= fcr_data[7:6];
      end
      if (flush) begin
        wr_ptr    <= '0;
        rd_ptr    <= '0;
        count     <= '0;
        break_ind <= 1'b0;
        tmo       <= '0;
        pend      <= 1'b0;
      end else begin
        if (accept) wr_ptr <= bump(wr_ptr);
        if (pop)    rd_ptr <= bump(rd_ptr);
        count <= next_count;

        if (rx_break)                        break_ind <= 1'b1;
        else if (pop && next_count == '0)    break_ind <= 1'b0;

        if (drop)           overrun_err <= 1'b1;
        else if (status_rd) overrun_err <= 1'b0;

        if (!fifo_on)                                        pend <= 1'b0;
        else if (rd_strobe)                                  pend <= 1'b0;
        else if (tmo == TMO_W'(1) && !accept && !pop)        pend <= 1'b1;

        if (!fifo_on || next_count == '0) tmo <= '0;
        else if (accept || pop)           tmo <= TMO_W'(TMO_LOAD);
        else if (tmo != '0)               tmo <= tmo - TMO_W'(1);
      end
    end
  end

  assign rx_count    = count;
  assign data_ready  = (count != '0);
  assign rd_data     = data_ready ? mem[rd_ptr] : 8'h00;
  assign rx_data_irq = rx_irq_en & data_ready & (~fifo_on | (count >= level));
  assign irq_code    = (rx_irq_en & pend) ? 2'b11 :
                       rx_data_irq        ? 2'b10 :
                       tx_empty_req       ? 2'b01 : 2'b00;

  assert_count_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= cap);

  assert_overrun_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == cap && !rd_strobe && !flush) |=>
      (rx_count == $past(rx_count) && rd_data == $past(rd_data) && overrun_err));

  assert_break_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !flush) |=> (break_ind && data_ready));

  assert_break_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    break_ind |-> data_ready);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_count == '0 && irq_code != 2'b11 && !break_ind));

  assert_pend_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> data_ready);

  assert_legacy_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_on |-> (rx_count <= CNT_W'(1) && !pend));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && count == '0 && !push && !flush) |=> (rx_count == '0 && rd_data == 8'h00));

endmodule

// File: tb/uart_rx_fifo_ctrl_tb_top.sv
module uart_rx_fifo_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CHARC = 16;
  localparam int T     = 4 * CHARC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcr_wr = 0, rx_valid = 0, rx_break = 0, rd_strobe = 0, status_rd = 0;
  logic rx_irq_en = 0, tx_empty_req = 0;
  logic [7:0] fcr_data = 0, rx_byte = 0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic data_ready, break_ind, overrun_err, rx_data_irq;
  logic [1:0] irq_code;

  always #2 clk = ~clk;

  uart_rx_fifo_ctrl #(.DEPTH(DEPTH), .CHAR_CYCLES(CHARC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_data(fcr_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rd_strobe(rd_strobe), .status_rd(status_rd), .rx_irq_en(rx_irq_en),
    .tx_empty_req(tx_empty_req), .rd_data(rd_data), .rx_count(rx_count),
    .data_ready(data_ready), .break_ind(break_ind), .overrun_err(overrun_err),
    .rx_data_irq(rx_data_irq), .irq_code(irq_code));

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mq[$];
  bit mon = 0, mbi = 0, moe = 0, mpend = 0;
  int mlvl = 1, mtmo = 0;

  function automatic int lvl_of(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_rd();
    return (mq.size() != 0) ? int'(mq[0]) : 0;
  endfunction

  function automatic int exp_irq();
    return (rx_irq_en && mq.size() != 0 && (!mon || mq.size() >= mlvl)) ? 1 : 0;
  endfunction

  function automatic int exp_code();
    if (rx_irq_en && mpend) return 3;
    if (exp_irq() != 0) return 2;
    if (tx_empty_req) return 1;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R7 head byte", int'(rd_data), exp_rd());
    check("R1 fill count", int'(rx_count), mq.size());
    check("R12 data ready", int'(data_ready), (mq.size() != 0) ? 1 : 0);
    check("R6 break flag", int'(break_ind), int'(mbi));
    check("R2 overrun flag", int'(overrun_err), int'(moe));
    check("R4 data irq", int'(rx_data_irq), exp_irq());
    check("R5 irq code", int'(irq_code), exp_code());
  endtask

  task automatic model_edge(input bit wr, input logic [7:0] fd, input bit v,
                            input logic [7:0] b, input bit brk, input bit rd, input bit srd);
    bit flush;
    flush = wr && (fd[1] || (fd[0] != mon));
    if (flush) begin
      mq.delete();
      mbi = 0; mtmo = 0; mpend = 0;
    end else begin
      bit pop, push, acc;
      int cap, after;
      pop = rd && mq.size() != 0;
      push = v || brk;
      cap = mon ? DEPTH : 1;
      after = mq.size() - (pop ? 1 : 0);
      acc = push && after < cap;
      if (pop) void'(mq.pop_front());
      if (acc) mq.push_back(brk ? 8'h00 : b);
      if (push && !acc) moe = 1;
      else if (srd) moe = 0;
      if (brk) mbi = 1;
      else if (pop && mq.size() == 0) mbi = 0;
      if (!mon) mpend = 0;
      else if (rd) mpend = 0;
      else if (mtmo == 1 && !acc && !pop) mpend = 1;
      if (!mon || mq.size() == 0) mtmo = 0;
      else if (acc || pop) mtmo = T;
      else if (mtmo > 0) mtmo--;
    end
    if (wr) begin
      mon = fd[0];
      mlvl = lvl_of(fd[7:6]);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] fd, input bit v,
                      input logic [7:0] b, input bit brk, input bit rd, input bit srd);
    fcr_wr = wr; fcr_data = fd; rx_valid = v; rx_byte = b;
    rx_break = brk; rd_strobe = rd; status_rd = srd;
    model_edge(wr, fd, v, b, brk, rd, srd);
    @(posedge clk);
    @(negedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle();          step(0, 8'h00, 0, 8'h00, 0, 0, 0); endtask
  task automatic push(input logic [7:0] b); step(0, 8'h00, 1, b, 0, 0, 0); endtask
  task automatic pull();          step(0, 8'h00, 0, 8'h00, 0, 1, 0); endtask
  task automatic fcr(input logic [7:0] d); step(1, d, 0, 8'h00, 0, 0, 0); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset count", int'(rx_count), 0);
    check("R12 reset ready", int'(data_ready), 0);
    check("R5 reset code", int'(irq_code), 0);
    compare_all();

    // Fill, overflow, and drain in FIFO mode at level 14
    rx_irq_en = 1;
    fcr(8'hC1);
    for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i));
    check("R3 level 14 reached", int'(rx_data_irq), 1);
    push(8'hEE);
    check("R2 drop keeps count", int'(rx_count), DEPTH);
    check("R2 overrun set", int'(overrun_err), 1);
    step(0, 8'h00, 0, 8'h00, 0, 0, 1);
    check("R2 overrun cleared", int'(overrun_err), 0);
    step(0, 8'h00, 1, 8'h77, 0, 1, 0);
    check("R2 push with read kept", int'(rx_count), DEPTH);
    check("R2 no overrun with read", int'(overrun_err), 0);
    for (int i = 1; i < DEPTH; i++) begin
      check("R1 order", int'(rd_data), 8'h10 + i);
      pull();
    end
    check("R2 last kept byte", int'(rd_data), 8'h77);
    pull();

    // Empty read
    pull();
    check("R11 empty read data", int'(rd_data), 0);
    check("R11 empty read count", int'(rx_count), 0);

    // Trigger levels
    for (int c = 0; c < 4; c++) begin
      int lv;
      lv = lvl_of(2'(c));
      fcr({2'(c), 6'b000001});
      for (int k = 0; k < lv - 1; k++) push(8'(k));
      check("R3 below level", int'(rx_data_irq), 0);
      push(8'hA5);
      check("R3 at level", int'(rx_data_irq), 1);
      fcr({2'(c), 6'b000011});
      check("R8 flush count", int'(rx_count), 0);
    end

    // Break
    step(0, 8'h00, 1, 8'h5A, 1, 0, 0);
    check("R6 break flag", int'(break_ind), 1);
    check("R6 break ready", int'(data_ready), 1);
    check("R6 break byte", int'(rd_data), 0);
    pull();
    check("R7 break cleared on empty", int'(break_ind), 0);

    // Character timeout
    fcr(8'hC1);
    push(8'h31);
    push(8'h32);
    repeat (T - 1) idle();
    check("R9 not yet pending", int'(irq_code == 2'b11), 0);
    idle();
    check("R9 timeout pending", int'(irq_code), 3);
    tx_empty_req = 1;
    idle();
    check("R5 timeout beats tx", int'(irq_code), 3);
    pull();
    check("R9 read clears pending", int'(irq_code == 2'b11), 0);
    repeat (T - 1) idle();
    check("R9 rearm not yet", int'(irq_code == 2'b11), 0);
    idle();
    check("R9 rearm pending", int'(irq_code), 3);
    fcr(8'hC3);
    check("R8 flush clears timeout", int'(irq_code), 1);
    check("R8 flush empties", int'(rx_count), 0);
    tx_empty_req = 0;

    // Non-FIFO mode
    push(8'h41);
    fcr(8'hC0);
    check("R10 mode change flushes", int'(rx_count), 0);
    push(8'h51);
    check("R4 legacy irq", int'(rx_data_irq), 1);
    check("R5 data code", int'(irq_code), 2);
    push(8'h52);
    check("R10 capacity one", int'(rx_count), 1);
    check("R10 overrun", int'(overrun_err), 1);
    check("R10 first kept", int'(rd_data), 8'h51);
    repeat (T + 4) idle();
    check("R10 no timeout", int'(irq_code), 2);
    pull();
    step(0, 8'h00, 0, 8'h00, 0, 0, 1);

    // Random traffic
    fcr(8'h81);
    for (int n = 0; n < 4000; n++) begin
      bit wr, v, brk, rd, srd;
      logic [7:0] fd;
      if (n % 50 == 0) rx_irq_en = 1'($urandom_range(0, 3) != 0);
      if (n % 30 == 0) tx_empty_req = 1'($urandom_range(0, 1));
      if (n % 600 == 300) repeat (T + 3) idle();
      wr  = ($urandom_range(0, 99) == 0);
      fd  = {2'($urandom_range(0, 3)), 4'b0000,
             1'($urandom_range(0, 9) == 0), 1'($urandom_range(0, 19) != 0)};
      v   = ($urandom_range(0, 3) == 0);
      brk = ($urandom_range(0, 59) == 0);
      rd  = ($urandom_range(0, 6) == 0);
      srd = ($urandom_range(0, 19) == 0);
      step(wr, fd, v, 8'($urandom_range(0, 255)), brk, rd, srd);
    end

    finish_run();
  end
endmodule